// File: doc/BRIEF.md
# Bus Lock Sequence Controller

This block supervises an atomic, locked access that a processor-side requester makes to one downstream port of a multi-port I/O fabric. The first locked read opens the lock. The block then forwards that read to the chosen port as a locked read request. It holds every other downstream port blocked while the lock lasts and follows the reads and writes that belong to the sequence. When the sequence ends, it unlocks the chosen port and lifts all blocking.

Only two shapes of sequence are legal: one read then one write, or two reads then two writes. Any other order is a protocol error. The error releases the lock and is flagged. A per-port configuration input marks each port as either a native endpoint or a bridge to legacy PCI. A lock opened on a native endpoint is reported, and an unsupported-request completion aborts the lock. A locked request aimed at a different port while a lock is held is stalled until the lock is released. Requests without the lock attribute do not affect the sequence.

Top module: `bus_lock_ctrl`

## Requirements
- R1: A locked read followed by a locked write to the same port completes the lock. One cycle after the write is accepted, `unlock_valid` pulses for one cycle, `busy` is 0 and `blk_port` is all zero.
- R2: Two locked reads followed by two locked writes to the same port complete the lock only on the second write. After the second read and after the first write, `busy` stays 1 and the blocking is unchanged.
- R3: One cycle after a locked read is accepted while idle, `lrd_valid` is 1 for exactly one cycle, `lrd_port` carries the request's port number, and `busy` is 1.
- R4: While `busy` is 1, bit i of `blk_port` is 1 for every port i other than the target port, and the target port's bit is 0.
- R5: Whenever the lock is released, `unlock_valid` pulses for one cycle and `unlock_port` names the target port. In that same cycle `busy` is 0 and `blk_port` is all zero. `blk_port` is all zero whenever `busy` is 0.
- R6: A pattern break raises `seq_err` for one cycle, one cycle after the offending request. A pattern break is a read arriving where a write is required, or a locked write arriving while idle. If a lock was held, the same cycle also shows the release of R5. A locked write while idle opens no lock.
- R7: While `busy` is 1, a completion with `cpl_valid`=1 and `cpl_ur`=1 aborts the lock. One cycle later `ur_abort` pulses together with the release of R5.
- R8: When a lock opens, `native_hit` pulses in the same cycle as `lrd_valid` if `port_native` bit p is 1 for target port p. It stays 0 for a port whose bit is 0, and a lock on such a port runs to completion.
- R9: While `busy` is 1, a request with `req_lock`=1 and a port other than the target sees `req_ready`=0 and has no effect. Once the lock is released, the same request is accepted.
- R10: A request with `req_valid`=1 and `req_lock`=0 changes neither `busy`, `blk_port` nor any pulse output, whether idle or locked.
- R11: During reset all outputs are 0 except `req_ready`, which is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_lock | input | 1 | Request carries the lock attribute |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | PORT_W | Downstream port the request targets |
| req_ready | output | 1 | 0 stalls a locked request to a non-target port |
| port_native | input | NUM_PORTS | Bit i = 1 marks port i as a native endpoint |
| cpl_valid | input | 1 | Completion returned from the target port |
| cpl_ur | input | 1 | Completion status is unsupported request |
| busy | output | 1 | Lock held |
| blk_port | output | NUM_PORTS | Per-port block, 1 = port blocked |
| lrd_valid | output | 1 | Locked read request pulse |
| lrd_port | output | PORT_W | Port for the locked read |
| unlock_valid | output | 1 | Unlock pulse |
| unlock_port | output | PORT_W | Port being unlocked |
| seq_err | output | 1 | Pattern break pulse |
| ur_abort | output | 1 | Lock aborted by unsupported-request completion |
| native_hit | output | 1 | Lock opened on a native endpoint port |

## Verification
The bench builds the block with NUM_PORTS = 4, so PORT_W = 2. Only port 3 is configured as a native endpoint. With four ports, each lock must block exactly three ports, which makes a wrong bit position in `blk_port` visible for every choice of target. The mix of one native port and three legacy ports lets the same run cover a lock that ends in an unsupported-request abort and locks that complete normally. A spare port is left free to present a competing lock during the stall case.

// File: rtl/bus_lock_pkg.sv
// Shared types for the bus lock sequence controller.
// Assumes: state encoding is private to the controller; no other block decodes it.
package bus_lock_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,  // no lock held
        SEQ_RD1  = 2'd1,  // one locked read seen
        SEQ_RD2  = 2'd2,  // two locked reads seen
        SEQ_WR1  = 2'd3   // two reads and one write seen
    } seq_state_e;
endpackage

// File: rtl/bus_lock_seq_fsm.sv
// Sequence tracker: follows the locked read/write pattern (R-W or R-R-W-W),
// remembers the target port and produces one-cycle events for start, release,
// pattern error and unsupported-request abort.
// Assumes: acc is only high for a locked request already qualified by req_ready.
module bus_lock_seq_fsm
    import bus_lock_pkg::*;
#(
    parameter int PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              acc_write,
    input  logic [PORT_W-1:0] acc_port,
    input  logic              cpl_valid,
    input  logic              cpl_ur,
    output logic              busy,
    output logic [PORT_W-1:0] tgt_port,
    output logic              ev_start,
    output logic              ev_release,
    output logic              ev_err,
    output logic              ev_ur
);
    seq_state_e state_q, state_d;
    logic       ev_done;
    logic       ur_hit;

    assign busy   = (state_q != SEQ_IDLE);
    assign ur_hit = busy && cpl_valid && cpl_ur;

    // Next-state and event decode for the lock pattern.
    always_comb begin
        state_d  = state_q;
        ev_start = 1'b0;
        ev_done  = 1'b0;
        ev_err   = 1'b0;
        ev_ur    = 1'b0;
        if (ur_hit) begin
            ev_ur   = 1'b1;
            state_d = SEQ_IDLE;
        end else if (acc) begin
            case (state_q)
                SEQ_IDLE: begin
                    if (acc_write) begin
                        ev_err = 1'b1;
                    end else begin
                        ev_start = 1'b1;
                        state_d  = SEQ_RD1;
                    end
                end
                SEQ_RD1: begin
                    if (acc_write) begin
                        ev_done = 1'b1;
                        state_d = SEQ_IDLE;
                    end else begin
                        state_d = SEQ_RD2;
                    end
                end
                SEQ_RD2: begin
                    if (acc_write) begin
                        state_d = SEQ_WR1;
                    end else begin
                        ev_err  = 1'b1;
                        state_d = SEQ_IDLE;
                    end
                end
                default: begin
                    if (acc_write) begin
                        ev_done = 1'b1;
                    end else begin
                        ev_err = 1'b1;
                    end
                    state_d = SEQ_IDLE;
                end
            endcase
        end
    end

    assign ev_release = ev_done || ev_ur || (ev_err && busy);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Capture the target port when a lock opens.
    always_ff @(posedge clk) begin
        if (!rst_n)        tgt_port <= '0;
        else if (ev_start) tgt_port <= acc_port;
    end

    // A lock in progress stays on one port until released.
    AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ev_release) |=> (tgt_port == $past(tgt_port))); // R4
endmodule

// File: rtl/bus_lock_port_mask.sv
// Per-port blocking register: on a lock start every port except the target
// is blocked; on release all ports are unblocked.
// Assumes: set and clr are never high in the same cycle.
module bus_lock_port_mask #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set,
    input  logic                 clr,
    input  logic [PORT_W-1:0]    port,
    output logic [NUM_PORTS-1:0] blk
);
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        // Block flag for one downstream port.
        always_ff @(posedge clk) begin
            if (!rst_n)   blk[g] <= 1'b0;
            else if (clr) blk[g] <= 1'b0;
            else if (set) blk[g] <= (port != PORT_W'(g));
        end
    end
endmodule

// File: rtl/bus_lock_ctrl.sv
// Top of the bus lock sequence controller. Qualifies locked requests, stalls
// competing locks, drives per-port blocking and the locked-read / unlock
// pulses, and flags pattern errors, unsupported-request aborts and locks that
// target a native endpoint.
// Assumes: req_port is below NUM_PORTS; completions only arrive for the target.
module bus_lock_ctrl #(
    parameter  int NUM_PORTS = 4,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_lock,
    input  logic                 req_write,
    input  logic [PORT_W-1:0]    req_port,
    output logic                 req_ready,
    input  logic [NUM_PORTS-1:0] port_native,
    input  logic                 cpl_valid,
    input  logic                 cpl_ur,
    output logic                 busy,
    output logic [NUM_PORTS-1:0] blk_port,
    output logic                 lrd_valid,
    output logic [PORT_W-1:0]    lrd_port,
    output logic                 unlock_valid,
    output logic [PORT_W-1:0]    unlock_port,
    output logic                 seq_err,
    output logic                 ur_abort,
    output logic                 native_hit
);
    logic              acc;
    logic [PORT_W-1:0] tgt_port;
    logic              ev_start, ev_release, ev_err, ev_ur;

    assign req_ready = !(busy && req_lock && (req_port != tgt_port));
    assign acc       = req_valid && req_lock && req_ready;

    bus_lock_seq_fsm #(.PORT_W(PORT_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .acc_write  (req_write),
        .acc_port   (req_port),
        .cpl_valid  (cpl_valid),
        .cpl_ur     (cpl_ur),
        .busy       (busy),
        .tgt_port   (tgt_port),
        .ev_start   (ev_start),
        .ev_release (ev_release),
        .ev_err     (ev_err),
        .ev_ur      (ev_ur)
    );

    bus_lock_port_mask #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) mask_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_start),
        .clr   (ev_release),
        .port  (req_port),
        .blk   (blk_port)
    );

    // Registered event pulses toward the target port and the requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrd_valid    <= 1'b0;
            lrd_port     <= '0;
            unlock_valid <= 1'b0;
            unlock_port  <= '0;
            seq_err      <= 1'b0;
            ur_abort     <= 1'b0;
            native_hit   <= 1'b0;
        end else begin
            lrd_valid    <= ev_start;
            unlock_valid <= ev_release;
            seq_err      <= ev_err;
            ur_abort     <= ev_ur;
            native_hit   <= ev_start && port_native[req_port];
            if (ev_start)   lrd_port    <= req_port;
            if (ev_release) unlock_port <= tgt_port;
        end
    end

    AST_OTHERS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(blk_port) == NUM_PORTS - 1)); // R4
    AST_TARGET_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !blk_port[tgt_port]); // R4
    AST_IDLE_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (blk_port == '0)); // R5
    AST_START_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> lrd_valid); // R3
    AST_END_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> unlock_valid); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !req_ready && !cpl_valid) |=> busy); // R9
    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ur_abort |-> (unlock_valid && !busy)); // R7
endmodule

// File: tb/bus_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_lock_ctrl_tb_top;
    localparam int NP = 4;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_lock, req_write;
    logic [PW-1:0] req_port;
    logic          req_ready;
    logic [NP-1:0] port_native;
    logic          cpl_valid, cpl_ur;
    logic          busy;
    logic [NP-1:0] blk_port;
    logic          lrd_valid, unlock_valid, seq_err, ur_abort, native_hit;
    logic [PW-1:0] lrd_port, unlock_port;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_lock_ctrl #(.NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_lock(req_lock), .req_write(req_write),
        .req_port(req_port), .req_ready(req_ready), .port_native(port_native),
        .cpl_valid(cpl_valid), .cpl_ur(cpl_ur), .busy(busy), .blk_port(blk_port),
        .lrd_valid(lrd_valid), .lrd_port(lrd_port), .unlock_valid(unlock_valid),
        .unlock_port(unlock_port), .seq_err(seq_err), .ur_abort(ur_abort),
        .native_hit(native_hit)
    );

    // Vector: {req4, vld, lock, wr, port2, cpl_ur, busy, blk4, lrd, unl, err}
    localparam logic [17:0] VEC [16] = '{
        18'b0011_1_1_0_01_0_1_1101_1_0_0, // R3 lock on port 1
        18'b0001_1_1_1_01_0_0_0000_0_1_0, // R1 write ends R-W
        18'b0101_0_0_0_00_0_0_0000_0_0_0, // R5 idle, nothing blocked
        18'b0100_1_1_0_10_0_1_1011_1_0_0, // R4 lock on port 2
        18'b0010_1_1_0_10_0_1_1011_0_0_0, // R2 second read
        18'b0010_1_1_1_10_0_1_1011_0_0_0, // R2 first write keeps lock
        18'b0010_1_1_1_10_0_0_0000_0_1_0, // R2 second write releases
        18'b1010_1_0_1_00_0_0_0000_0_0_0, // R10 unlocked write idle
        18'b0110_1_1_1_00_0_0_0000_0_0_1, // R6 locked write while idle
        18'b0011_1_1_0_00_0_1_1110_1_0_0, // R3 lock on port 0
        18'b0110_1_1_0_00_0_1_1110_0_0_0, // R6 second read
        18'b0110_1_1_0_00_0_0_0000_0_1_1, // R6 third read breaks
        18'b0011_1_1_0_00_0_1_1110_1_0_0, // R3 lock on port 0 again
        18'b1010_1_0_1_10_0_1_1110_0_0_0, // R10 unlocked write during lock
        18'b0111_0_0_0_00_1_0_0000_0_1_0, // R7 UR completion aborts
        18'b1010_1_0_0_10_0_0_0000_0_0_0  // R10 unlocked read idle
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic l, input logic w, input logic [PW-1:0] p, input logic c);
        req_valid = v; req_lock = l; req_write = w; req_port = p;
        cpl_valid = c; cpl_ur = c;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        port_native = 4'b1000;
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11", "outputs", {busy, blk_port, lrd_valid, unlock_valid, seq_err, ur_abort, native_hit}, 0);
        chk("R11", "req_ready", req_ready, 1);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            drive(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:9], VEC[i][8]);
            @(posedge clk); #1;
            chk($sformatf("R%0d", VEC[i][17:14]), $sformatf("vector %0d", i),
                {busy, blk_port, lrd_valid, unlock_valid, seq_err}, VEC[i][7:0]);
        end

        // R8 native port 3: hit flagged, then R7 UR abort releases port 3
        @(negedge clk); drive(1, 1, 0, 3, 0);
        @(posedge clk); #1;
        chk("R8", "native_hit port3", native_hit, 1);
        chk("R3", "lrd_port", lrd_port, 3);
        @(negedge clk); drive(0, 0, 0, 0, 1);
        @(posedge clk); #1;
        chk("R7", "ur_abort", ur_abort, 1);
        chk("R5", "unlock_port", unlock_port, 3);
        chk("R5", "busy after abort", busy, 0);

        // R8 legacy port 1: no hit; R9 competing lock stalled
        @(negedge clk); drive(1, 1, 0, 1, 0);
        @(posedge clk); #1;
        chk("R8", "native_hit port1", native_hit, 0);
        @(negedge clk); drive(1, 1, 0, 2, 0); #1;
        chk("R9", "req_ready stalled", req_ready, 0);
        @(posedge clk); #1;
        chk("R9", "state held", {busy, blk_port, lrd_valid}, 9'b1_1101_0);
        @(negedge clk); drive(1, 1, 1, 1, 0); #1;
        chk("R9", "req_ready target", req_ready, 1);
        @(posedge clk); #1;
        chk("R8", "legacy lock completes", unlock_valid, 1);
        chk("R5", "unlock_port", unlock_port, 1);
        @(negedge clk); drive(1, 1, 0, 2, 0); #1;
        chk("R9", "req_ready after release", req_ready, 1);
        @(posedge clk); #1;
        chk("R9", "stalled lock accepted", {lrd_valid, lrd_port}, 3'b1_10);
        @(negedge clk); drive(1, 1, 1, 2, 0);
        @(posedge clk); #1;
        chk("R1", "port2 release", {busy, unlock_valid}, 2'b01);
        @(negedge clk); drive(0, 0, 0, 0, 0);
        @(posedge clk); #1;
        chk("R5", "pulse one cycle", {unlock_valid, lrd_valid, seq_err}, 0);

        done = 1'b1;
        finish_run();
    end
endmodule